// File: doc/BRIEF.md
# Feature-Access Control Register Permission Checker

This block decides what happens to a system-register read or write aimed at the feature-access control register. Software can reach that register through three accessor encodings: its plain name, an alias that is meant for a host kernel running at the hypervisor level, and an alias that applies a write mask. For each request, the checker looks at several inputs:

- the accessor used and the direction of the access;
- the current exception level;
- whether the monitor level (EL3) is present;
- whether the hypervisor level (EL2) is enabled;
- the coarse trap bits that the higher levels own;
- the fine-grained trap controls;
- the three nested-virtualisation control bits;
- the host-mode flag.

It produces exactly one verdict: undefined, trap to EL2, trap to EL3, access the real register, access the EL2 twin register, or turn the access into a memory access at a fixed offset.

The decision is an ordered chain of checks, and the chain differs by exception level and by accessor. A pipeline issues a request strobe together with its qualifiers. One clock later it receives a registered, one-hot verdict, a class code for traps and a memory offset for redirects. The register storage itself is outside this block.

Top module: `sra_checker`

## Requirements
- R1: An access from EL0 (`cur_el`=0), or through the reserved accessor code 3, gives the undefined verdict. Accessor codes are: 0 plain name, 1 host alias, 2 mask alias.
- R2: At EL1 through the plain name or the mask alias, EL3 present with `el3_trap` and `el3_undef_prio` all set gives undefined. This check outranks every other check.
- R3: At EL1 through the plain name, the fine-grained check runs after R2. The first check traps to EL2 when `el2_enabled` and `el2_trap` are both set. Failing that, the access traps to EL2 when `fgt_present` and `el2_enabled` are set, when `el3_fgt_en` is set or EL3 is absent, and when the direction's own bit is set (`fgt_rd_trap` for reads, `fgt_wr_trap` for writes).
- R4: At EL1, after the EL2 checks, EL3 present with `el3_trap` traps to EL3. It gives undefined instead when `sec_debug_undef` is set.
- R5: At EL1 through the plain name or the mask alias, when no earlier check fired, `nv_bits`=3'b111 redirects the access to memory with `rsp_offset`=0x100. Any other value accesses the real register.
- R6: At EL2 through the plain name or the mask alias, the EL3 checks of R2 and R4 apply first. After them, `host_mode` selects the EL2 twin register; otherwise the real register is accessed.
- R7: At EL3 through the plain name or the mask alias, the real register is always accessed, whatever the trap inputs are.
- R8: At EL1 through the host alias, `nv_bits`=3'b101 redirects to memory at offset 0x100. Otherwise any value with `nv_bits[0]`=1 traps to EL2, and every other value gives undefined.
- R9: At EL2 or EL3 through the host alias, the access is undefined unless `host_mode` is set. At EL2 with `host_mode` set, the EL3 checks of R2 and R4 apply, and the real register is accessed if neither fires. At EL3 with `host_mode` set, the real register is accessed.
- R10: At EL1 through the mask alias, the fine-grained step of R3 is replaced. The access traps to EL2 when `fgt_present` and `el2_enabled` are set and either `mask_alias_bit` is 0 or EL3 is present with `el3_fgt2_en` at 0.
- R11: A request strobe gives `rsp_valid` exactly one cycle later, and no strobe gives no response. The verdict bit positions are: bit0 undefined, bit1 trap EL2, bit2 trap EL3, bit3 real register, bit4 twin register, bit5 memory. Exactly one bit is set. `rsp_class` is 0x18 on either trap and 0 otherwise. `rsp_offset` is 0x100 on a memory redirect and 0 otherwise.
- R12: During and directly after synchronous reset, `rsp_valid`, `rsp_result`, `rsp_class` and `rsp_offset` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| acc_kind | input | 2 | Accessor: 0 plain, 1 host alias, 2 mask alias, 3 reserved |
| is_write | input | 1 | 1 for a write, 0 for a read |
| cur_el | input | 2 | Current exception level |
| el3_present | input | 1 | Monitor level implemented |
| el2_enabled | input | 1 | Hypervisor level implemented and enabled in this security state |
| el2_trap | input | 1 | Hypervisor trap bit for this register |
| el3_trap | input | 1 | Monitor trap bit for this register |
| el3_undef_prio | input | 1 | Monitor condition that turns its trap into a high-priority undefined |
| sec_debug_undef | input | 1 | Secure-debug condition that turns a monitor trap into undefined |
| fgt_present | input | 1 | Fine-grained trap feature implemented |
| el3_fgt_en | input | 1 | Monitor enable for fine-grained traps |
| fgt_rd_trap | input | 1 | Fine-grained read trap bit |
| fgt_wr_trap | input | 1 | Fine-grained write trap bit |
| el3_fgt2_en | input | 1 | Monitor enable for second-generation fine-grained traps |
| mask_alias_bit | input | 1 | Negative-polarity fine-grained bit for the mask alias |
| nv_bits | input | 3 | Nested-virtualisation controls |
| host_mode | input | 1 | Host (EL2-hosted kernel) mode flag |
| rsp_valid | output | 1 | Response valid, one cycle after the strobe |
| rsp_result | output | 6 | One-hot verdict |
| rsp_class | output | 6 | Trap class code (0x18 on traps) |
| rsp_offset | output | 12 | Memory redirect offset (0x100 on redirect) |

## Verification
The in-module assertions check four properties on every response. The response must arrive exactly one cycle after its strobe and never without one. The verdict must be one-hot. Traps must carry the class code and redirects the offset. EL0 and EL3 plain-name accesses must resolve to their fixed verdicts. Only the bench's scenarios can show the priority order between competing checks: the high-priority undefined ahead of the hypervisor trap, the hypervisor traps ahead of the monitor trap, and the monitor trap ahead of the memory redirect. The same holds for the host-alias decoding of the nested bits and the replaced fine-grained rule of the mask alias. The bench pits those inputs against one another in a long pseudo-random sweep and in directed cases.

// File: rtl/sra_pkg.sv
package sra_pkg;

    typedef enum logic [1:0] {
        ACC_PLAIN = 2'd0,
        ACC_HOST  = 2'd1,
        ACC_MASK  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        V_UNDEF = 3'd0,
        V_TRAP2 = 3'd1,
        V_TRAP3 = 3'd2,
        V_REAL  = 3'd3,
        V_TWIN  = 3'd4,
        V_MEM   = 3'd5
    } verdict_e;

    localparam int unsigned N_VERDICTS = 6;

    typedef struct packed {
        logic       is_write;
        logic       el3_present;
        logic       el2_enabled;
        logic       el2_trap;
        logic       el3_trap;
        logic       el3_undef_prio;
        logic       sec_debug_undef;
        logic       fgt_present;
        logic       el3_fgt_en;
        logic       fgt_rd_trap;
        logic       fgt_wr_trap;
        logic       el3_fgt2_en;
        logic       mask_alias_bit;
        logic [2:0] nv_bits;
        logic       host_mode;
    } ctl_t;

    typedef struct packed {
        logic     hit;
        verdict_e v;
    } step_t;

    // Monitor checks that sit ahead of everything at EL2
    function automatic step_t el3_prio_step(ctl_t c);
        step_t s;
        s.hit = c.el3_present && c.el3_trap && c.el3_undef_prio;
        s.v   = V_UNDEF;
        return s;
    endfunction

    // Monitor trap step, placed after the EL2 checks at EL1
    function automatic step_t el3_trap_step(ctl_t c);
        step_t s;
        s.hit = c.el3_present && c.el3_trap;
        s.v   = c.sec_debug_undef ? V_UNDEF : V_TRAP3;
        return s;
    endfunction

    function automatic logic [N_VERDICTS-1:0] to_onehot(verdict_e v);
        logic [N_VERDICTS-1:0] oh;
        oh = '0;
        oh[v] = 1'b1;
        return oh;
    endfunction

endpackage

// File: rtl/sra_el1_chain.sv
module sra_el1_chain
    import sra_pkg::*;
#(
    parameter logic [2:0] NV_REDIRECT = 3'b111,
    parameter logic [2:0] NV_HOST_MEM = 3'b101
) (
    input  ctl_t     ctl,
    input  acc_e     kind,
    output verdict_e verdict
);

    logic  fgt_plain;
    logic  fgt_mask;
    logic  fgt_hit;
    step_t prio_s;
    step_t trap3_s;

    always_comb begin
        fgt_plain = ctl.fgt_present && ctl.el2_enabled
                 && (!ctl.el3_present || ctl.el3_fgt_en)
                 && (ctl.is_write ? ctl.fgt_wr_trap : ctl.fgt_rd_trap);
        fgt_mask  = ctl.fgt_present && ctl.el2_enabled
                 && ((ctl.el3_present && !ctl.el3_fgt2_en) || !ctl.mask_alias_bit);
        fgt_hit   = (kind == ACC_MASK) ? fgt_mask : fgt_plain;
        prio_s    = el3_prio_step(ctl);
        trap3_s   = el3_trap_step(ctl);
    end

    always_comb begin
        if (kind == ACC_HOST) begin
            if (ctl.nv_bits == NV_HOST_MEM)  verdict = V_MEM;
            else if (ctl.nv_bits[0])         verdict = V_TRAP2;
            else                             verdict = V_UNDEF;
        end else if (prio_s.hit)                         verdict = prio_s.v;
        else if (ctl.el2_enabled && ctl.el2_trap)       verdict = V_TRAP2;
        else if (fgt_hit)                               verdict = V_TRAP2;
        else if (trap3_s.hit)                           verdict = trap3_s.v;
        else if (ctl.nv_bits == NV_REDIRECT)            verdict = V_MEM;
        else                                            verdict = V_REAL;
    end

endmodule

// File: rtl/sra_upper_chain.sv
module sra_upper_chain
    import sra_pkg::*;
(
    input  ctl_t     ctl,
    input  acc_e     kind,
    input  logic     at_el3,
    output verdict_e verdict
);

    step_t prio_s;
    step_t trap3_s;
    logic  gate_hit;
    verdict_e gate_v;

    always_comb begin
        prio_s  = el3_prio_step(ctl);
        trap3_s = el3_trap_step(ctl);
        // At EL2 the monitor checks come first; EL3 is never gated by itself
        gate_hit = !at_el3 && (prio_s.hit || trap3_s.hit);
        gate_v   = prio_s.hit ? prio_s.v : trap3_s.v;
    end

    always_comb begin
        if (kind == ACC_HOST) begin
            if (!ctl.host_mode)   verdict = V_UNDEF;
            else if (gate_hit)    verdict = gate_v;
            else                  verdict = V_REAL;
        end else if (at_el3)      verdict = V_REAL;
        else if (gate_hit)        verdict = gate_v;
        else if (ctl.host_mode)   verdict = V_TWIN;
        else                      verdict = V_REAL;
    end

endmodule

// File: rtl/sra_checker.sv
module sra_checker
    import sra_pkg::*;
#(
    parameter int unsigned CLASS_W     = 6,
    parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18,
    parameter int unsigned OFS_W       = 12,
    parameter logic [OFS_W-1:0] MEM_OFFSET = 12'h100,
    parameter logic [2:0] NV_REDIRECT  = 3'b111,
    parameter logic [2:0] NV_HOST_MEM  = 3'b101
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [1:0]         acc_kind,
    input  logic               is_write,
    input  logic [1:0]         cur_el,
    input  logic               el3_present,
    input  logic               el2_enabled,
    input  logic               el2_trap,
    input  logic               el3_trap,
    input  logic               el3_undef_prio,
    input  logic               sec_debug_undef,
    input  logic               fgt_present,
    input  logic               el3_fgt_en,
    input  logic               fgt_rd_trap,
    input  logic               fgt_wr_trap,
    input  logic               el3_fgt2_en,
    input  logic               mask_alias_bit,
    input  logic [2:0]         nv_bits,
    input  logic               host_mode,
    output logic               rsp_valid,
    output logic [N_VERDICTS-1:0] rsp_result,
    output logic [CLASS_W-1:0] rsp_class,
    output logic [OFS_W-1:0]   rsp_offset
);

    ctl_t     ctl;
    acc_e     kind;
    verdict_e v_el1;
    verdict_e v_upper;
    verdict_e v_final;

    always_comb begin
        ctl = '{is_write:        is_write,
                el3_present:     el3_present,
                el2_enabled:     el2_enabled,
                el2_trap:        el2_trap,
                el3_trap:        el3_trap,
                el3_undef_prio:  el3_undef_prio,
                sec_debug_undef: sec_debug_undef,
                fgt_present:     fgt_present,
                el3_fgt_en:      el3_fgt_en,
                fgt_rd_trap:     fgt_rd_trap,
                fgt_wr_trap:     fgt_wr_trap,
                el3_fgt2_en:     el3_fgt2_en,
                mask_alias_bit:  mask_alias_bit,
                nv_bits:         nv_bits,
                host_mode:       host_mode};
        kind = acc_e'(acc_kind);
    end

    sra_el1_chain #(
        .NV_REDIRECT (NV_REDIRECT),
        .NV_HOST_MEM (NV_HOST_MEM)
    ) u_el1 (
        .ctl     (ctl),
        .kind    (kind),
        .verdict (v_el1)
    );

    sra_upper_chain u_upper (
        .ctl     (ctl),
        .kind    (kind),
        .at_el3  (cur_el == 2'd3),
        .verdict (v_upper)
    );

    always_comb begin
        if (cur_el == 2'd0 || kind == ACC_RSVD) v_final = V_UNDEF;
        else if (cur_el == 2'd1)                v_final = v_el1;
        else                                    v_final = v_upper;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_result <= '0;
            rsp_class  <= '0;
            rsp_offset <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_result <= req_valid ? to_onehot(v_final) : '0;
            rsp_class  <= (req_valid && (v_final == V_TRAP2 || v_final == V_TRAP3))
                          ? TRAP_CLASS : '0;
            rsp_offset <= (req_valid && v_final == V_MEM) ? MEM_OFFSET : '0;
        end
    end

    // R11: response follows a strobe by one cycle, and only then
    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R11: exactly one verdict per response
    p_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones(rsp_result) == 1));
    // R11: class code accompanies traps, offset accompanies redirects
    p_class_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_result[1] || rsp_result[2])) |-> (rsp_class == TRAP_CLASS));
    p_offset_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_result[5]) |-> (rsp_offset == MEM_OFFSET));
    // R1: EL0 always undefined
    p_el0_undef_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_el == 2'd0) |=> rsp_result[0]);
    // R7: EL3 through the plain name reaches the real register
    p_el3_real_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_el == 2'd3 && acc_kind == 2'd0) |=> rsp_result[3]);

endmodule

// File: tb/sra_checker_test.sv
module sra_checker_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  acc_kind;
    logic        is_write;
    logic [1:0]  cur_el;
    logic        el3_present, el2_enabled, el2_trap, el3_trap, el3_undef_prio;
    logic        sec_debug_undef, fgt_present, el3_fgt_en, fgt_rd_trap, fgt_wr_trap;
    logic        el3_fgt2_en, mask_alias_bit, host_mode;
    logic [2:0]  nv_bits;
    logic        rsp_valid;
    logic [5:0]  rsp_result;
    logic [5:0]  rsp_class;
    logic [11:0] rsp_offset;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    localparam logic [5:0] E_UNDEF = 6'b000001;
    localparam logic [5:0] E_TRAP2 = 6'b000010;
    localparam logic [5:0] E_TRAP3 = 6'b000100;
    localparam logic [5:0] E_REAL  = 6'b001000;
    localparam logic [5:0] E_TWIN  = 6'b010000;
    localparam logic [5:0] E_MEM   = 6'b100000;

    always #2 clk = ~clk;

    sra_checker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .acc_kind(acc_kind),
        .is_write(is_write), .cur_el(cur_el), .el3_present(el3_present),
        .el2_enabled(el2_enabled), .el2_trap(el2_trap), .el3_trap(el3_trap),
        .el3_undef_prio(el3_undef_prio), .sec_debug_undef(sec_debug_undef),
        .fgt_present(fgt_present), .el3_fgt_en(el3_fgt_en),
        .fgt_rd_trap(fgt_rd_trap), .fgt_wr_trap(fgt_wr_trap),
        .el3_fgt2_en(el3_fgt2_en), .mask_alias_bit(mask_alias_bit),
        .nv_bits(nv_bits), .host_mode(host_mode),
        .rsp_valid(rsp_valid), .rsp_result(rsp_result),
        .rsp_class(rsp_class), .rsp_offset(rsp_offset)
    );

    // Independent reference: returns expected verdict and the rule it exercises
    task automatic model(output logic [5:0] exp, output string tag);
        bit pr   = el3_present && el3_trap && el3_undef_prio;
        bit t3   = el3_present && el3_trap;
        bit fgtp = fgt_present && el2_enabled && (!el3_present || el3_fgt_en) &&
                   (is_write ? fgt_wr_trap : fgt_rd_trap);
        bit fgtm = fgt_present && el2_enabled &&
                   (!mask_alias_bit || (el3_present && !el3_fgt2_en));
        if (cur_el == 0 || acc_kind == 3) begin exp = E_UNDEF; tag = "R1"; end
        else if (acc_kind == 1) begin
            if (cur_el == 1) begin
                tag = "R8";
                if (nv_bits == 3'b101) exp = E_MEM;
                else if (nv_bits[0])   exp = E_TRAP2;
                else                   exp = E_UNDEF;
            end else begin
                tag = "R9";
                if (!host_mode)                exp = E_UNDEF;
                else if (cur_el == 2 && pr)    exp = E_UNDEF;
                else if (cur_el == 2 && t3)    exp = sec_debug_undef ? E_UNDEF : E_TRAP3;
                else                           exp = E_REAL;
            end
        end else if (cur_el == 3) begin exp = E_REAL; tag = "R7"; end
        else if (cur_el == 2) begin
            tag = "R6";
            if (pr)             exp = E_UNDEF;
            else if (t3)        exp = sec_debug_undef ? E_UNDEF : E_TRAP3;
            else if (host_mode) exp = E_TWIN;
            else                exp = E_REAL;
        end else begin
            if (pr) begin exp = E_UNDEF; tag = "R2"; end
            else if (el2_enabled && el2_trap) begin exp = E_TRAP2; tag = "R3"; end
            else if (acc_kind == 0 && fgtp) begin exp = E_TRAP2; tag = "R3"; end
            else if (acc_kind == 2 && fgtm) begin exp = E_TRAP2; tag = "R10"; end
            else if (t3) begin exp = sec_debug_undef ? E_UNDEF : E_TRAP3; tag = "R4"; end
            else if (nv_bits == 3'b111) begin exp = E_MEM; tag = "R5"; end
            else begin exp = E_REAL; tag = "R5"; end
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        req_valid = 0; acc_kind = 0; is_write = 0; cur_el = 1;
        el3_present = 0; el2_enabled = 0; el2_trap = 0; el3_trap = 0;
        el3_undef_prio = 0; sec_debug_undef = 0; fgt_present = 0; el3_fgt_en = 0;
        fgt_rd_trap = 0; fgt_wr_trap = 0; el3_fgt2_en = 0; mask_alias_bit = 1;
        nv_bits = 0; host_mode = 0;
    endtask

    // Drive on the falling edge, sample after the next rising edge
    task automatic issue(string force_tag, logic [5:0] force_exp, bit use_force);
        logic [5:0] exp;
        string tag;
        model(exp, tag);
        if (use_force) begin
            chk({force_tag, " model"}, {26'd0, exp}, {26'd0, force_exp});
            tag = force_tag;
        end
        req_valid = 1;
        @(posedge clk); #1;
        req_valid = 0;
        chk(tag, {26'd0, rsp_result}, {26'd0, exp});
        chk("R11 valid", {31'd0, rsp_valid}, 32'd1);
        chk("R11 class", {26'd0, rsp_class},
            (exp == E_TRAP2 || exp == E_TRAP3) ? 32'h18 : 32'h0);
        chk("R11 offset", {20'd0, rsp_offset}, (exp == E_MEM) ? 32'h100 : 32'h0);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        clear_inputs();
        rst = 1;
        req_valid = 1;
        repeat (3) @(posedge clk);
        #1;
        chk("R12 valid", {31'd0, rsp_valid}, 32'd0);
        chk("R12 result", {26'd0, rsp_result}, 32'd0);
        chk("R12 class", {26'd0, rsp_class}, 32'd0);
        chk("R12 offset", {20'd0, rsp_offset}, 32'd0);
        @(negedge clk);
        req_valid = 0;
        rst = 0;
        @(posedge clk); #1;
        chk("R12 after release", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);

        // R11: idle cycle gives no response
        clear_inputs();
        @(posedge clk); #1;
        chk("R11 idle", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);

        // R1: EL0 with every permission open, and reserved accessor
        clear_inputs(); cur_el = 0; host_mode = 1;
        issue("R1", E_UNDEF, 1);
        clear_inputs(); acc_kind = 3; cur_el = 3;
        issue("R1", E_UNDEF, 1);

        // R2: priority undefined beats the EL2 trap
        clear_inputs(); el3_present = 1; el3_trap = 1; el3_undef_prio = 1;
        el2_enabled = 1; el2_trap = 1;
        issue("R2", E_UNDEF, 1);

        // R3: EL2 trap beats EL3 trap; fine-grained write bit only on writes
        clear_inputs(); el2_enabled = 1; el2_trap = 1; el3_present = 1; el3_trap = 1;
        issue("R3", E_TRAP2, 1);
        clear_inputs(); el2_enabled = 1; fgt_present = 1; fgt_wr_trap = 1; is_write = 1;
        issue("R3", E_TRAP2, 1);
        clear_inputs(); el2_enabled = 1; fgt_present = 1; fgt_wr_trap = 1; is_write = 0;
        issue("R3", E_REAL, 1);
        clear_inputs(); el2_enabled = 1; fgt_present = 1; fgt_rd_trap = 1;
        el3_present = 1; el3_fgt_en = 0;
        issue("R3", E_REAL, 1);

        // R4: EL3 trap, and the secure-debug undefined variant
        clear_inputs(); el3_present = 1; el3_trap = 1; nv_bits = 3'b111;
        issue("R4", E_TRAP3, 1);
        sec_debug_undef = 1;
        issue("R4", E_UNDEF, 1);

        // R5: redirect and its neighbours
        clear_inputs(); nv_bits = 3'b111;
        issue("R5", E_MEM, 1);
        nv_bits = 3'b110;
        issue("R5", E_REAL, 1);

        // R6: EL2 host twin versus real, EL3 trap first
        clear_inputs(); cur_el = 2; host_mode = 1; el2_trap = 1; el2_enabled = 1;
        issue("R6", E_TWIN, 1);
        host_mode = 0;
        issue("R6", E_REAL, 1);
        el3_present = 1; el3_trap = 1; host_mode = 1;
        issue("R6", E_TRAP3, 1);

        // R7: EL3 ignores every trap
        clear_inputs(); cur_el = 3; el3_present = 1; el3_trap = 1; el3_undef_prio = 1;
        nv_bits = 3'b111;
        issue("R7", E_REAL, 1);

        // R8: host alias at EL1 over every nested-bit value
        for (int n = 0; n < 8; n++) begin
            clear_inputs(); acc_kind = 1; nv_bits = n[2:0];
            issue("R8", (n == 5) ? E_MEM : (n[0] ? E_TRAP2 : E_UNDEF), 1);
        end

        // R9: host alias at EL2/EL3
        clear_inputs(); acc_kind = 1; cur_el = 3;
        issue("R9", E_UNDEF, 1);
        host_mode = 1;
        issue("R9", E_REAL, 1);
        cur_el = 2; el3_present = 1; el3_trap = 1;
        issue("R9", E_TRAP3, 1);

        // R10: mask alias uses its own fine-grained rule
        clear_inputs(); acc_kind = 2; fgt_present = 1; el2_enabled = 1; mask_alias_bit = 0;
        issue("R10", E_TRAP2, 1);
        mask_alias_bit = 1; el3_present = 1; el3_fgt2_en = 0;
        issue("R10", E_TRAP2, 1);
        el3_fgt2_en = 1; fgt_rd_trap = 1; el3_fgt_en = 1;
        issue("R10", E_REAL, 1);

        // Broad sweep over all inputs
        for (int i = 0; i < 12000; i++) begin
            logic [31:0] r;
            r = $urandom;
            acc_kind = r[1:0]; is_write = r[2]; cur_el = r[4:3];
            el3_present = r[5]; el2_enabled = r[6]; el2_trap = r[7] & r[19];
            el3_trap = r[8] & r[20]; el3_undef_prio = r[9]; sec_debug_undef = r[10];
            fgt_present = r[11]; el3_fgt_en = r[12]; fgt_rd_trap = r[13];
            fgt_wr_trap = r[14]; el3_fgt2_en = r[15]; mask_alias_bit = r[16];
            nv_bits = r[23:21]; host_mode = r[17];
            issue("", 6'd0, 0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule